// File: doc/BRIEF.md
# Interrupt Pin Steering Router

This block takes four interrupt request pins from expansion devices and places each of them on one line of a sixteen-line request vector for a legacy interrupt controller. Every pin passes through a two-flop synchronizer first. The conditioning of each pin is then chosen on its own. In the bus-standard setting, a low pin requests for as long as it stays low. In the alternative setting, a rising edge on the pin produces a single one-clock request, as older expansion interrupts do.

Two registers control the block through a small register port. The trigger register holds one mode bit per pin. The steering register holds one 4-bit line selector per pin. A selector of zero leaves its pin unconnected. Lines 0 and 2 are kept out of reach of the router. When several pins land on one line, their requests are combined. The output vector is registered.

Top module: `pirq_steer`

## Requirements
- R1: Reset (synchronous, active low) clears both registers to zero and drives `irq_req` to all zeros. While reset is held, and in the first cycle after reset, `irq_req` is all zeros.
- R2: Address 0 holds the trigger register: bit 0 is pin 0, bit 1 pin 1, bit 2 pin 2, bit 3 pin 3. Address 1 holds the steering register: pin 0 in bits 3:0, pin 1 in 7:4, pin 2 in 11:8, pin 3 in 15:12. Both registers read back what was written.
- R3: Writes to bits 15:4 at address 0 are ignored. These bits always read 0, and they have no effect on the conditioning.
- R4: With trigger bit 0 (level), a low pin drives its selected line high continuously. A change on the pin shows on `irq_req` at the third rising clock edge after the change.
- R5: With trigger bit 1 (edge), a rising edge on the pin gives exactly one high cycle on the selected line, at the third clock edge. A pin that stays high gives no further pulse, and a falling pin gives none.
- R6: A selector value of 0 leaves the pin unconnected. A selector value N drives line N.
- R7: Lines 0 and 2 are never driven, even when a pin selects them.
- R8: Requests from several pins that select one line are ORed together.
- R9: A pin already high when edge mode is selected after reset produces no pulse.
- R10: A new selector value takes effect on the clock edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_pin | input | 4 | Raw asynchronous interrupt pins, pin 0 at bit 0 |
| reg_addr | input | 1 | Register select: 0 trigger, 1 steering |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |
| irq_req | output | 16 | Registered legacy request lines |

## Verification
A steering write and a live pin request can land in the same cycle. The bench holds a level request on one line, then rewrites the selector while the pin stays low. It checks that on the edge after the write the request has moved to the new line and nothing is left on the old one. An edge pulse and a level request can also meet on a shared line. The vector table places two asserted pins on one line and expects a single high bit with no interference between them.

// File: rtl/pirq_pkg.sv
// Package: shared sizes, register addresses and trigger encoding for
// the interrupt pin steering router.
package pirq_pkg;
    localparam int unsigned PIN_CNT  = 4;
    localparam int unsigned SEL_W    = 4;
    localparam int unsigned LINE_CNT = 1 << SEL_W;
    localparam int unsigned REG_W    = PIN_CNT * SEL_W;

    // Lines the router must never drive.
    localparam logic [LINE_CNT-1:0] BLOCKED_LINES = 16'h0005;

    localparam logic ADDR_TRIG  = 1'b0;
    localparam logic ADDR_STEER = 1'b1;

    typedef enum logic {
        TRIG_LEVEL_LOW = 1'b0,
        TRIG_EDGE_HIGH = 1'b1
    } trig_e;
endpackage

// File: rtl/pirq_sync.sv
// Module: pirq_sync
// Two-flop synchronizer for each asynchronous pin.
// Assumes: the flops preset to 1 on reset, so that a pin held high through
// reset is never seen as a rising edge later.
module pirq_sync #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q;
        logic sync_q;

        // Two-stage capture of one pin, preset high on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
            end else begin
                meta_q <= d_in[g];
                sync_q <= meta_q;
            end
        end

        assign q_out[g] = sync_q;
    end
endmodule

// File: rtl/pirq_cond.sv
// Module: pirq_cond
// Turns each synchronized pin into an active-high request. Level mode:
// the request is the inverted pin. Edge mode: the request is a one-cycle
// strobe on a rising edge.
// Assumes: the inputs are already synchronized, and the history flop uses
// the same reset and preset value as the synchronizer.
module pirq_cond #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_in,
    input  logic [W-1:0] edge_mode,
    output logic [W-1:0] req_out
);
    import pirq_pkg::*;

    logic [W-1:0] hist_q;

    // Keep the previous synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '1;
        else        hist_q <= sync_in;
    end

    for (genvar g = 0; g < W; g++) begin : g_pin
        // Select the conditioning for one pin.
        always_comb begin
            if (trig_e'(edge_mode[g]) == TRIG_EDGE_HIGH)
                req_out[g] = sync_in[g] & ~hist_q[g];
            else
                req_out[g] = ~sync_in[g];
        end
    end
endmodule

// File: rtl/pirq_regs.sv
// Module: pirq_regs
// Holds the trigger register and the steering register, with a single-cycle
// write and a combinational read.
// Assumes: the write data is as wide as the steering register.
module pirq_regs #(
    parameter int unsigned PINS  = 4,
    parameter int unsigned SEL_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_addr,
    input  logic                    reg_we,
    input  logic [PINS*SEL_W-1:0]   reg_wdata,
    output logic [PINS*SEL_W-1:0]   reg_rdata,
    output logic [PINS-1:0]         trig_q,
    output logic [PINS*SEL_W-1:0]   steer_q
);
    import pirq_pkg::*;
    localparam int unsigned DW = PINS * SEL_W;

    // Trigger register: only the per-pin bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                              trig_q <= '0;
        else if (reg_we && reg_addr == ADDR_TRIG) trig_q <= reg_wdata[PINS-1:0];
    end

    // Steering register: one selector per pin.
    always_ff @(posedge clk) begin
        if (!rst_n)                               steer_q <= '0;
        else if (reg_we && reg_addr == ADDR_STEER) steer_q <= reg_wdata;
    end

    // Read multiplexer; reserved trigger bits read as zero.
    always_comb begin
        if (reg_addr == ADDR_TRIG) reg_rdata = {{(DW-PINS){1'b0}}, trig_q};
        else                       reg_rdata = steer_q;
    end
endmodule

// File: rtl/pirq_route.sv
// Module: pirq_route
// Decodes each pin's selector, ORs the requests per line, masks the
// blocked lines and registers the result.
// Assumes: selector value 0 is unconnected (line 0 is always blocked).
module pirq_route #(
    parameter int unsigned              PINS  = 4,
    parameter int unsigned              SEL_W = 4,
    parameter int unsigned              LINES = 1 << SEL_W,
    parameter logic [(1<<SEL_W)-1:0]    BLOCK = 16'h0005
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PINS-1:0]       req_in,
    input  logic [PINS*SEL_W-1:0] steer_in,
    output logic [LINES-1:0]      lines_out
);
    logic [LINES-1:0] hit;

    // Merge every active pin onto the line its selector names.
    always_comb begin
        hit = '0;
        for (int p = 0; p < PINS; p++) begin
            if (req_in[p]) hit[steer_in[p*SEL_W +: SEL_W]] = 1'b1;
        end
    end

    // Register the masked line vector.
    always_ff @(posedge clk) begin
        if (!rst_n) lines_out <= '0;
        else        lines_out <= hit & ~BLOCK;
    end
endmodule

// File: rtl/pirq_steer.sv
// Module: pirq_steer (top)
// Interrupt pin steering router: synchronize, condition per pin, then
// steer onto a sixteen-line legacy request vector.
// Assumes: the pins are asynchronous; the register port is synchronous to clk.
module pirq_steer
    import pirq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PIN_CNT-1:0]  irq_pin,
    input  logic                reg_addr,
    input  logic                reg_we,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    output logic [LINE_CNT-1:0] irq_req
);
    logic [PIN_CNT-1:0] pin_sync;
    logic [PIN_CNT-1:0] trig_q;
    logic [REG_W-1:0]   steer_q;
    logic [PIN_CNT-1:0] cond_req;

    pirq_sync #(.W(PIN_CNT)) i_sync (
        .clk(clk), .rst_n(rst_n), .d_in(irq_pin), .q_out(pin_sync)
    );

    pirq_regs #(.PINS(PIN_CNT), .SEL_W(SEL_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .trig_q(trig_q), .steer_q(steer_q)
    );

    pirq_cond #(.W(PIN_CNT)) i_cond (
        .clk(clk), .rst_n(rst_n), .sync_in(pin_sync),
        .edge_mode(trig_q), .req_out(cond_req)
    );

    pirq_route #(.PINS(PIN_CNT), .SEL_W(SEL_W), .LINES(LINE_CNT),
                 .BLOCK(BLOCKED_LINES)) i_route (
        .clk(clk), .rst_n(rst_n), .req_in(cond_req),
        .steer_in(steer_q), .lines_out(irq_req)
    );
endmodule

// File: rtl/pirq_steer_chk.sv
// Module: pirq_steer_chk
// Assertion checker bound to pirq_steer.
module pirq_steer_chk
    import pirq_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                reg_addr,
    input logic [REG_W-1:0]    reg_rdata,
    input logic [LINE_CNT-1:0] irq_req,
    input logic [PIN_CNT-1:0]  trig_q,
    input logic [REG_W-1:0]    steer_q,
    input logic [PIN_CNT-1:0]  cond_req
);
    function automatic logic names_line(input logic [REG_W-1:0] s, input int unsigned l);
        logic r = 1'b0;
        for (int p = 0; p < PIN_CNT; p++)
            if (s[p*SEL_W +: SEL_W] == SEL_W'(l)) r = 1'b1;
        return r;
    endfunction

    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> irq_req == '0);

    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == ADDR_TRIG |-> reg_rdata[REG_W-1:PIN_CNT] == '0);

    p_blocked_lines_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req[0] == 1'b0 && irq_req[2] == 1'b0);

    for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
        p_edge_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_q[p] && cond_req[p]) |=> (!cond_req[p] || !trig_q[p]));
    end

    for (genvar l = 0; l < LINE_CNT; l++) begin : g_line
        p_unselected_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !names_line($past(steer_q), l) |-> !irq_req[l]);
    end
endmodule

bind pirq_steer pirq_steer_chk i_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .trig_q(trig_q), .steer_q(steer_q), .cond_req(cond_req)
);

// File: tb/test_pirq_steer.sv
`timescale 1ns/1ps
module test_pirq_steer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  irq_pin = 4'hF;
    logic        reg_addr = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] irq_req;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pirq_steer i_pirq_steer (
        .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req)
    );

    // {steering, pins (low = request), expected lines}, level mode
    localparam logic [35:0] VEC [8] = '{
        {16'h0000, 4'b0000, 16'h0000},  // R6 all unconnected
        {16'h4321, 4'b0000, 16'h001A},  // R7 line 2 blocked
        {16'h5555, 4'b1110, 16'h0020},  // R8 shared line, one pin
        {16'h5555, 4'b1111, 16'h0000},  // R4 released pins
        {16'hF9A7, 4'b0101, 16'h8400},  // R6 selectors 10 and 15
        {16'h0C0C, 4'b1010, 16'h1000},  // R8 two pins on line 12
        {16'h0002, 4'b0000, 16'h0000},  // R7 only line 2 selected
        {16'hEDCB, 4'b0000, 16'h7800}   // R6 lines 11..14
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic a, input logic [15:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1 chk(req, reg_rdata, exp);
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cycles(3);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt;
        // R1 reset state
        do_reset();
        chk("R1 irq", irq_req, 16'h0000);
        rd("R1 trig", 1'b0, 16'h0000);
        rd("R1 steer", 1'b1, 16'h0000);

        // R2 / R3 register access
        wr(1'b1, 16'hA5C3);
        rd("R2 steer", 1'b1, 16'hA5C3);
        wr(1'b0, 16'hFFFF);
        rd("R2 R3 trig", 1'b0, 16'h000F);
        wr(1'b0, 16'hFFF0);
        rd("R3 trig", 1'b0, 16'h0000);

        // vector table, level mode
        for (int v = 0; v < 8; v++) begin
            wr(1'b1, VEC[v][35:20]);
            irq_pin = VEC[v][19:16];
            cycles(4);
            chk($sformatf("R4 R6 R7 R8 vec%0d", v), irq_req, VEC[v][15:0]);
        end

        // R3: reserved writes leave pin 0 in level mode
        irq_pin = 4'hF;
        wr(1'b1, 16'h0005);
        wr(1'b0, 16'h00F0);
        irq_pin = 4'hE;
        cycles(4);
        chk("R3 level kept", irq_req, 16'h0020);

        // R4 latency: change shows at the third edge
        irq_pin = 4'hF;
        cycles(4);
        @(negedge clk) irq_pin = 4'hE;
        cycles(2);
        chk("R4 before", irq_req, 16'h0000);
        cycles(1);
        chk("R4 at third", irq_req, 16'h0020);

        // R10: steering change with the pin held low
        wr(1'b1, 16'h0003);
        cycles(1);
        chk("R10 moved", irq_req, 16'h0008);

        // R5 edge mode on pin 0, line 6
        irq_pin = 4'hF;
        wr(1'b1, 16'h0006);
        wr(1'b0, 16'h0001);
        irq_pin = 4'hE;
        cnt = 0;
        for (int i = 0; i < 6; i++) begin cycles(1); if (irq_req[6]) cnt++; end
        chk("R5 fall none", 16'(cnt), 16'h0000);
        irq_pin = 4'hF;
        cycles(2);
        chk("R5 pre", irq_req, 16'h0000);
        cycles(1);
        chk("R5 pulse", irq_req, 16'h0040);
        cycles(1);
        chk("R5 one cycle", irq_req, 16'h0000);
        cnt = 0;
        for (int i = 0; i < 8; i++) begin cycles(1); if (irq_req != 0) cnt++; end
        chk("R5 held none", 16'(cnt), 16'h0000);

        // R9: pins high through reset, then edge mode
        irq_pin = 4'hF;
        do_reset();
        wr(1'b1, 16'h7654);
        wr(1'b0, 16'h000F);
        cnt = 0;
        for (int i = 0; i < 10; i++) begin cycles(1); if (irq_req != 0) cnt++; end
        chk("R9 no false edge", 16'(cnt), 16'h0000);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule